// File: doc/BRIEF.md
# FIFO Chain Depth-Expansion Controller

This block is the token logic for one FIFO that sits in a ring of identical FIFOs. Together the ring behaves as one deep queue. Only the device that holds the write token accepts writes, and only the device that holds the read token may drive its data outputs and accept reads. When the token holder fills its last memory location it passes the write right on with a one-cycle low pulse to the next device. Emptying its last location passes the read right on in the same way.

The expansion inputs are sampled while reset is asserted, and this sets the mode. An expansion output idles high, so a chained input is high during reset. A grounded input is low, and this selects standalone mode. In standalone mode the device keeps both tokens permanently, sends no read pulses, and its write-expansion pin carries an active-low half-full indication instead.

The memory array, the pointers and the flags sit outside this block. The pointer logic supplies the request and last-location signals.

Top module: `daisy_depth_ctl`

## Requirements
- R1: At every write-clock edge with `rst_n` low, the block latches the mode. It is standalone (`single_mode`=1) if `wexp_in_n` or `rexp_in_n` is 0, and chained otherwise. The mode holds while `rst_n` is high.
- R2: After reset in chained mode, both `wr_token` and `rd_token` are 1 when `first_n` is 0 and both are 0 when `first_n` is 1. In both modes, `wexp_out_n` and `rexp_out_n` show no pulse after reset.
- R3: `wr_en` is 1 exactly when `wr_req` is 1 and `wr_token` is 1. A write request without the token has no effect on the token and sends no pulse.
- R4: In chained mode, an accepted write with `wr_last`=1 at a write-clock edge clears `wr_token` and drives `wexp_out_n` low for the following cycle only, unless R10 applies. At all other times in chained mode, `wexp_out_n` is high.
- R5: In chained mode, `wexp_in_n` low at a write-clock edge sets `wr_token` after that edge.
- R6: `rd_en` is 1 exactly when `rd_req` is 1 and `rd_token` is 1. `q_oe` equals `rd_token`. A read request without the token has no effect.
- R7: In chained mode, an accepted read with `rd_last`=1 at a read-clock edge clears `rd_token` and drives `rexp_out_n` low for the following cycle only, unless R10 applies. At all other times, `rexp_out_n` is high.
- R8: In chained mode, `rexp_in_n` low at a read-clock edge sets `rd_token` after that edge.
- R9: In standalone mode, both tokens stay 1, `rexp_out_n` stays 1, and `wexp_out_n` equals the inverse of `half_full`.
- R10: When a token is given up and taken at the same edge, the device still holds the token afterwards, and the outgoing pulse is still sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Synchronous active-low reset, sampled on both clocks |
| first_n | input | 1 | Low marks the device that starts with both tokens |
| wexp_in_n | input | 1 | Write pulse from the previous device (low active), also a mode strap |
| rexp_in_n | input | 1 | Read pulse from the previous device (low active), also a mode strap |
| wr_req | input | 1 | Write attempt from the pointer logic |
| wr_last | input | 1 | Write pointer is at the last memory location |
| rd_req | input | 1 | Read attempt from the pointer logic |
| rd_last | input | 1 | Read pointer is at the last memory location |
| half_full | input | 1 | Half-full flag from the flag logic, used in standalone mode |
| wr_en | output | 1 | Write accepted this cycle |
| rd_en | output | 1 | Read accepted this cycle |
| wr_token | output | 1 | Device holds the write right |
| rd_token | output | 1 | Device holds the read right |
| q_oe | output | 1 | Data output drive enable |
| wexp_out_n | output | 1 | Write pulse to the next device, or inverted half-full in standalone mode |
| rexp_out_n | output | 1 | Read pulse to the next device |
| single_mode | output | 1 | Latched mode, 1 for standalone |

## Verification
Two situations are hard to reach from the ports. The first is the edge where a device gives up a token and receives it back at the same time. The second is the mode, which can only change during reset. The stimulus forces the simultaneous give-and-take on both sides with directed steps. It then repeats the reset several times with different strap and first-device settings. Within each of these runs, random requests, last-location hints and incoming pulses drive long sequences, and a bench model follows the tokens and pulses for that mode.

// File: rtl/daisy_depth_ctl.sv
module daisy_depth_ctl (
  input  logic wr_clk,
  input  logic rd_clk,
  input  logic rst_n,
  input  logic first_n,
  input  logic wexp_in_n,
  input  logic rexp_in_n,
  input  logic wr_req,
  input  logic wr_last,
  input  logic rd_req,
  input  logic rd_last,
  input  logic half_full,
  output logic wr_en,
  output logic rd_en,
  output logic wr_token,
  output logic rd_token,
  output logic q_oe,
  output logic wexp_out_n,
  output logic rexp_out_n,
  output logic single_mode
);
  logic strap, single_w, single_r;
  logic wtok, rtok, wpulse, rpulse;
  logic wgive, rgive;

  assign strap = !(wexp_in_n && rexp_in_n);
  assign wgive = wr_req && wtok && wr_last;
  assign rgive = rd_req && rtok && rd_last;

  always_ff @(posedge wr_clk) begin
    if (!rst_n) begin
      single_w <= strap;
      wtok     <= !first_n || strap;
      wpulse   <= 1'b0;
    end else begin
      wpulse <= !single_w && wgive;
      wtok   <= single_w || (wtok && !wgive) || !wexp_in_n;
    end
  end

  always_ff @(posedge rd_clk) begin
    if (!rst_n) begin
      single_r <= strap;
      rtok     <= !first_n || strap;
      rpulse   <= 1'b0;
    end else begin
      rpulse <= !single_r && rgive;
      rtok   <= single_r || (rtok && !rgive) || !rexp_in_n;
    end
  end

  assign wr_en       = wr_req && wtok;
  assign rd_en       = rd_req && rtok;
  assign wr_token    = wtok;
  assign rd_token    = rtok;
  assign q_oe        = rtok;
  assign single_mode = single_w;
  assign wexp_out_n  = single_w ? !half_full : !wpulse;
  assign rexp_out_n  = !rpulse;

  assert_wr_give_R4: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (!single_mode && wr_en && wr_last && wexp_in_n) |=> (!wexp_out_n && !wr_token));
  assert_wr_take_R5: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (!single_mode && !wexp_in_n) |=> wr_token);
  assert_rd_give_R7: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!single_r && rd_en && rd_last && rexp_in_n) |=> (!rexp_out_n && !q_oe));
  assert_rd_take_R8: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!single_r && !rexp_in_n) |=> rd_token);
  assert_take_wins_R10: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (!single_mode && wr_en && wr_last && !wexp_in_n) |=> (wr_token && !wexp_out_n));
  assert_single_hold_R9: assert property (@(posedge rd_clk) disable iff (!rst_n)
    single_r |=> (rd_token && rexp_out_n));
  assert_mode_stable_R1: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(single_mode));
endmodule

// File: tb/daisy_depth_ctl_tb.sv
module daisy_depth_ctl_tb_top;
  logic clk = 1'b0;
  logic rst_n, first_n, wexp_in_n, rexp_in_n, wr_req, wr_last, rd_req, rd_last, half_full;
  logic wr_en, rd_en, wr_token, rd_token, q_oe, wexp_out_n, rexp_out_n, single_mode;
  int errors = 0, checks = 0, cycles = 0;
  bit done = 1'b0;
  bit m_single, m_wtok, m_rtok, m_wp, m_rp;

  always #5 clk = ~clk;

  daisy_depth_ctl dut_i (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .first_n(first_n),
    .wexp_in_n(wexp_in_n), .rexp_in_n(rexp_in_n), .wr_req(wr_req), .wr_last(wr_last),
    .rd_req(rd_req), .rd_last(rd_last), .half_full(half_full),
    .wr_en(wr_en), .rd_en(rd_en), .wr_token(wr_token), .rd_token(rd_token), .q_oe(q_oe),
    .wexp_out_n(wexp_out_n), .rexp_out_n(rexp_out_n), .single_mode(single_mode));

  task automatic chk(input logic act, input bit exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit next_tok(bit single, bit tok, bit req, bit last, bit in_n);
    return single || (tok && !(req && last)) || !in_n;
  endfunction

  task automatic do_reset(input bit first, input bit win, input bit rin);
    rst_n = 1'b0; first_n = first; wexp_in_n = win; rexp_in_n = rin;
    wr_req = 0; wr_last = 0; rd_req = 0; rd_last = 0; half_full = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_single = !(win && rin);
    m_wtok = !first || m_single; m_rtok = m_wtok; m_wp = 0; m_rp = 0;
    if (!m_single) begin wexp_in_n = 1; rexp_in_n = 1; end
    #1;
    chk(single_mode, m_single, "R1", "single_mode after reset");
    chk(wr_token, m_wtok, "R2", "wr_token after reset");
    chk(rd_token, m_rtok, "R2", "rd_token after reset");
    chk(rexp_out_n, 1'b1, "R2", "rexp_out_n after reset");
    if (!m_single) chk(wexp_out_n, 1'b1, "R2", "wexp_out_n after reset");
  endtask

  task automatic step(input bit wq, input bit wl, input bit wi, input bit rq, input bit rl,
                      input bit ri, input bit hf);
    string tw, tr;
    @(negedge clk);
    wr_req = wq; wr_last = wl; wexp_in_n = wi; rd_req = rq; rd_last = rl; rexp_in_n = ri;
    half_full = hf;
    #1;
    tw = m_single ? "R9" : "R4 R5 R10";
    tr = m_single ? "R9" : "R7 R8 R10";
    chk(wr_en, wq && m_wtok, "R3", "wr_en");
    chk(rd_en, rq && m_rtok, "R6", "rd_en");
    chk(q_oe, m_rtok, "R6", "q_oe");
    chk(wr_token, m_wtok, tw, "wr_token");
    chk(rd_token, m_rtok, tr, "rd_token");
    chk(wexp_out_n, m_single ? !hf : !m_wp, tw, "wexp_out_n");
    chk(rexp_out_n, !m_rp, tr, "rexp_out_n");
    chk(single_mode, m_single, "R1", "single_mode held");
    m_wp = !m_single && wq && m_wtok && wl;
    m_rp = !m_single && rq && m_rtok && rl;
    m_wtok = next_tok(m_single, m_wtok, wq, wl, wi);
    m_rtok = next_tok(m_single, m_rtok, rq, rl, ri);
  endtask

  task automatic rand_steps(input int n, input bit single);
    for (int i = 0; i < n; i++) begin
      bit wi, ri;
      wi = ($urandom % 8) != 0;
      ri = ($urandom % 8) != 0;
      step($urandom % 2, ($urandom % 4) == 0, wi, $urandom % 2, ($urandom % 4) == 0, ri,
           single ? $urandom % 2 : 0);
    end
  endtask

  initial begin
    while (!done && cycles < 100000) begin @(posedge clk); cycles++; end
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // first device, chained: R2, R3, R4, R5
    do_reset(0, 1, 1);
    step(1, 0, 1, 0, 0, 1, 0);   // write, not last: token kept (R3)
    step(1, 1, 1, 0, 0, 1, 0);   // write at last: hand off (R4)
    step(0, 0, 1, 0, 0, 1, 0);   // pulse visible, token gone (R4)
    step(1, 1, 1, 0, 0, 1, 0);   // write without token ignored (R3)
    step(0, 0, 0, 0, 0, 1, 0);   // incoming pulse (R5)
    step(1, 1, 0, 0, 0, 1, 0);   // give and take together (R10)
    step(0, 0, 1, 0, 0, 1, 0);
    // read side: R6, R7, R8, R10
    step(0, 0, 1, 1, 1, 1, 0);   // read at last (R7)
    step(0, 0, 1, 1, 1, 1, 0);   // read without token ignored (R6)
    step(0, 0, 1, 0, 0, 0, 0);   // take (R8)
    step(0, 0, 1, 1, 1, 0, 0);   // give and take together (R10)
    step(0, 0, 1, 0, 0, 1, 0);
    rand_steps(3000, 0);
    // later device in the chain: R2
    do_reset(1, 1, 1);
    step(1, 1, 1, 1, 1, 1, 0);   // no tokens: both ignored (R3, R6)
    rand_steps(3000, 0);
    // standalone via grounded write input, then read input: R1, R9
    do_reset(0, 0, 1);
    rand_steps(1000, 1);
    do_reset(1, 1, 0);
    rand_steps(1000, 1);
    do_reset(0, 1, 1);
    rand_steps(500, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule